// File: doc/BRIEF.md
# Task-Switched Flag Control Unit

This unit owns the task-switched flag of a 32-bit machine control register and executes the single privileged instruction that clears it. Each cycle it may receive one decoded instruction. This consists of two opcode bytes, a lock-prefix indication, the current privilege level and the processor operating mode. It may also receive a strobe reporting that a hardware task switch has taken place.

When the instruction is the flag-clearing one, the unit checks legality. A lock prefix is an invalid-opcode fault in every mode. Virtual-8086 mode always rejects the instruction. Protected, compatibility and 64-bit modes require privilege level 0. Real-address mode needs no privilege at all, so start-up code can prepare the flag before protected mode is entered. One cycle later the unit reports exactly one result: a retire pulse, or a fault pulse carrying a fault class and an error code.

A task-switch strobe always sets the flag. When a strobe meets a successful clear in the same cycle, the set wins. The other 31 bits of the register keep their reset value and are never written by this unit.

Top module: `tsflag_ctl`

## Requirements
- R1: The instruction is recognised only when `instr_valid` is high, `op_b0` is 8'h0F and `op_b1` is 8'h06; a permitted instruction gives `retire_o` high for exactly the following cycle.
- R2: A permitted instruction makes `cr_q[3]` 0 from the following cycle; bits other than 3 never differ from `CR_INIT`.
- R3: With `lock_pfx` high, a recognised instruction gives `fault_o` high next cycle with `fault_cls` = 2'd1 (invalid opcode) in every mode and at every privilege level, the lock check ranking above all others, and the flag is unchanged.
- R4: In modes 3'd1 (protected), 3'd3 (compatibility) and 3'd4 (64-bit), a recognised unlocked instruction with `cpl` not 0 gives `fault_o` next cycle with `fault_cls` = 2'd2 (general protection) and `fault_err` = 0, with the flag unchanged; with `cpl` = 0 it retires.
- R5: In mode 3'd2 (virtual-8086) a recognised unlocked instruction always gives `fault_cls` = 2'd2 and `fault_err` = 0 at any `cpl`, with the flag unchanged.
- R6: In mode 3'd0 (real address) a recognised unlocked instruction retires at any `cpl`.
- R7: A high `ts_event` sets `cr_q[3]` to 1 from the following cycle.
- R8: When `ts_event` and a permitted clear occur in the same cycle, `cr_q[3]` is 1 afterwards, and the instruction still retires.
- R9: Any other opcode pair, or `instr_valid` low, leaves the register unchanged and gives no retire and no fault.
- R10: After reset `cr_q` equals `CR_INIT` with bit 3 at 0, and `retire_o`, `fault_o`, `fault_cls` and `fault_err` are 0.
- R11: `retire_o` and `fault_o` are never high together; when `fault_o` is low, `fault_cls` is 2'd0 and `fault_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented this cycle |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte |
| lock_pfx | input | 1 | Lock prefix present |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| ts_event | input | 1 | Hardware task-switch strobe |
| cr_q | output | 32 | Control register value, flag in bit 3 |
| retire_o | output | 1 | One-cycle pulse: instruction completed |
| fault_o | output | 1 | One-cycle pulse: instruction faulted |
| fault_cls | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| fault_err | output | 16 | Error code of the fault |

## Verification
The bench drives every mode with every privilege level, with the lock prefix on and off. Mode and privilege legality are therefore separated from the lock ranking: a locked instruction at privilege 3 must give invalid-opcode and not general-protection. Task-switch strobes are timed alone, against a successful clear and against a faulting one, to expose the set/clear race and any stray clear on a fault. Near-miss opcodes and invalid cycles with the right bytes show that recognition needs both bytes and the valid bit. A reference model in the bench predicts the flag and the result of every cycle of a long seeded random run.

// File: rtl/tsflag_ctl.sv
module tsflag_ctl #(
  parameter int          CR_W    = 32,
  parameter int          FLAG_POS = 3,
  parameter int          ERR_W   = 16,
  parameter logic [31:0] CR_INIT = 32'h6000_0011,
  parameter logic [7:0]  OPC_B0  = 8'h0F,
  parameter logic [7:0]  OPC_B1  = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [7:0]       op_b0,
  input  logic [7:0]       op_b1,
  input  logic             lock_pfx,
  input  logic [1:0]       cpl,
  input  logic [2:0]       cpu_mode,
  input  logic             ts_event,
  output logic [31:0]      cr_q,
  output logic             retire_o,
  output logic             fault_o,
  output logic [1:0]       fault_cls,
  output logic [15:0]      fault_err
);
  localparam logic [2:0] M_REAL = 3'd0;
  localparam logic [2:0] M_V86  = 3'd2;
  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_UD   = 2'd1;
  localparam logic [1:0] C_GP   = 2'd2;
  localparam logic [CR_W-1:0] KEEP_MASK = ~(CR_W'(1) << FLAG_POS);
  localparam logic [CR_W-1:0] BASE = CR_W'(CR_INIT) & KEEP_MASK;

  logic flag_q;
  logic hit, bad_ud, bad_gp, ok;
  logic [1:0] cls_d;

  assign hit    = instr_valid && (op_b0 == OPC_B0) && (op_b1 == OPC_B1);
  assign bad_ud = hit && lock_pfx;
  assign bad_gp = hit && !lock_pfx &&
                  ((cpu_mode == M_V86) || ((cpu_mode != M_REAL) && (cpl != 2'd0)));
  assign ok     = hit && !lock_pfx && !bad_gp;
  assign cls_d  = bad_ud ? C_UD : (bad_gp ? C_GP : C_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      retire_o  <= 1'b0;
      fault_o   <= 1'b0;
      fault_cls <= C_NONE;
      fault_err <= '0;
    end else begin
      if (ts_event)
        flag_q <= 1'b1;
      else if (ok)
        flag_q <= 1'b0;
      retire_o  <= ok;
      fault_o   <= bad_ud || bad_gp;
      fault_cls <= cls_d;
      fault_err <= ERR_W'(0);
    end
  end

  assign cr_q = BASE | (CR_W'(flag_q) << FLAG_POS);
endmodule

// File: rtl/tsflag_ctl_chk.sv
module tsflag_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [7:0]  op_b0,
  input logic [7:0]  op_b1,
  input logic        lock_pfx,
  input logic [1:0]  cpl,
  input logic [2:0]  cpu_mode,
  input logic        ts_event,
  input logic [31:0] cr_q,
  input logic        retire_o,
  input logic        fault_o,
  input logic [1:0]  fault_cls,
  input logic [15:0] fault_err
);
  logic hit;
  logic pm;
  assign hit = instr_valid && op_b0 == 8'h0F && op_b1 == 8'h06;
  assign pm  = cpu_mode == 3'd1 || cpu_mode == 3'd3 || cpu_mode == 3'd4;

  AST_LOCK_UD: assert property (@(posedge clk) disable iff (!rst_n)
    hit && lock_pfx |=> fault_o && fault_cls == 2'd1); // R3
  AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && lock_pfx && !ts_event |=> $stable(cr_q)); // R3
  AST_PM_GP: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && pm && cpl != 2'd0 |=> fault_o && fault_cls == 2'd2 && fault_err == 16'd0); // R4
  AST_V86_GP: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && cpu_mode == 3'd2 |=> fault_o && fault_cls == 2'd2 && fault_err == 16'd0); // R5
  AST_REAL_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && cpu_mode == 3'd0 |=> retire_o); // R6
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !lock_pfx && cpu_mode == 3'd0 && !ts_event |=> !cr_q[3]); // R2
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ts_event |=> cr_q[3]); // R7
  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({cr_q[31:4], cr_q[2:0]})); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !retire_o && !fault_o); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_o && fault_o)); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> fault_cls == 2'd0 && fault_err == 16'd0); // R11
endmodule

bind tsflag_ctl tsflag_ctl_chk chk_i (.*);

// File: tb/tsflag_ctl_tb_top.sv
`timescale 1ns/1ps
module tsflag_ctl_tb_top;
  localparam logic [31:0] INIT = 32'h6000_0011;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [7:0] op_b0 = 8'h00, op_b1 = 8'h00;
  logic lock_pfx = 1'b0;
  logic [1:0] cpl = 2'd0;
  logic [2:0] cpu_mode = 3'd0;
  logic ts_event = 1'b0;
  logic [31:0] cr_q;
  logic retire_o, fault_o;
  logic [1:0] fault_cls;
  logic [15:0] fault_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic m_flag = 1'b0;

  always #4 clk = ~clk;

  tsflag_ctl dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] exp_cls(logic v, logic [7:0] b0, logic [7:0] b1,
                                         logic lk, logic [1:0] pl, logic [2:0] md);
    if (!(v && b0 == 8'h0F && b1 == 8'h06)) return 2'd0;
    if (lk) return 2'd1;
    if (md == 3'd2) return 2'd2;
    if (md != 3'd0 && pl != 2'd0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic exp_ret(logic v, logic [7:0] b0, logic [7:0] b1,
                                   logic lk, logic [1:0] pl, logic [2:0] md);
    return v && b0 == 8'h0F && b1 == 8'h06 && exp_cls(v, b0, b1, lk, pl, md) == 2'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [7:0] b0, logic [7:0] b1,
                      logic lk, logic [1:0] pl, logic [2:0] md, logic ev);
    logic r;
    logic [1:0] c;
    instr_valid = v; op_b0 = b0; op_b1 = b1; lock_pfx = lk;
    cpl = pl; cpu_mode = md; ts_event = ev;
    r = exp_ret(v, b0, b1, lk, pl, md);
    c = exp_cls(v, b0, b1, lk, pl, md);
    if (ev) m_flag = 1'b1;
    else if (r) m_flag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({req, " cr"}, cr_q, (INIT & ~32'h8) | {28'd0, m_flag, 3'd0});
    chk({req, " retire"}, {31'd0, retire_o}, {31'd0, r});
    chk({req, " fault"}, {31'd0, fault_o}, {31'd0, c != 2'd0});
    chk({req, " class"}, {30'd0, fault_cls}, {30'd0, c});
    chk({req, " err"}, {16'd0, fault_err}, 32'd0);
    instr_valid = 1'b0; ts_event = 1'b0;
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset cr", cr_q, INIT & ~32'h8);
    chk("R10 reset pulses", {30'd0, retire_o, fault_o}, 32'd0);
    chk("R10 reset class/err", {14'd0, fault_cls, fault_err}, 32'd0);

    step("R7 event sets", 0, 8'h00, 8'h00, 0, 0, 3'd1, 1);
    step("R1 R2 pm cpl0 clears", 1, 8'h0F, 8'h06, 0, 0, 3'd1, 0);
    step("R7 event again", 0, 8'h0F, 8'h06, 0, 0, 3'd1, 1);
    step("R3 lock at cpl3 is UD", 1, 8'h0F, 8'h06, 1, 3, 3'd1, 0);
    step("R3 lock in real", 1, 8'h0F, 8'h06, 1, 0, 3'd0, 0);
    step("R5 v86 cpl0 GP", 1, 8'h0F, 8'h06, 0, 0, 3'd2, 0);
    step("R4 compat cpl1 GP", 1, 8'h0F, 8'h06, 0, 1, 3'd3, 0);
    step("R4 64-bit cpl3 GP", 1, 8'h0F, 8'h06, 0, 3, 3'd4, 0);
    step("R9 near miss byte1", 1, 8'h0F, 8'h07, 0, 0, 3'd0, 0);
    step("R9 near miss byte0", 1, 8'h0E, 8'h06, 0, 0, 3'd0, 0);
    step("R9 valid low", 0, 8'h0F, 8'h06, 0, 0, 3'd0, 0);
    step("R6 real cpl3 retires", 1, 8'h0F, 8'h06, 0, 3, 3'd0, 0);
    step("R8 event beats clear", 1, 8'h0F, 8'h06, 0, 0, 3'd4, 1);
    step("R4 64-bit cpl0 retires", 1, 8'h0F, 8'h06, 0, 0, 3'd4, 0);
    step("R7 event with GP fault", 1, 8'h0F, 8'h06, 0, 2, 3'd2, 1);
    step("R11 idle", 0, 8'h00, 8'h00, 0, 0, 3'd0, 0);

    for (int i = 0; i < 600; i++) begin
      logic hitp;
      logic [7:0] b0, b1;
      hitp = ($urandom % 10) < 7;
      b0 = hitp ? 8'h0F : 8'($urandom);
      b1 = hitp ? 8'h06 : 8'($urandom);
      step("R1-random R3 R4 R5 R6 R7 R8 R9", ($urandom % 8) != 0, b0, b1,
           ($urandom % 5) == 0, 2'($urandom), 3'($urandom % 5), ($urandom % 6) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule